// File: doc/BRIEF.md
# Transmit Preamble and Header Sequencer

This block produces the serial bit stream that precedes the payload in a spread-spectrum transmitter. A one-cycle start pulse captures the frame configuration: the header mode, the ready lead count, the constant-rate option, the payload modulation request and the signal, service and length values. The block then emits a run of ones as the preamble, followed by a 16-bit start frame delimiter. Depending on the 2-bit mode, signal, service, length and checksum fields follow. When the last header bit has been sent, the block passes control to the payload source.

Every header bit is flagged as differential BPSK. When the header is done, the modulation flag carries the payload modulation. A ready level goes to the data source a programmable number of clocks before the first payload clock. When the constant-rate option is set, the clock runs at the faster payload rate throughout the frame, so each header bit is held for two clocks. Spreading, scrambling, modulation and the radio are handled downstream.

Top module: `txhdr_seq`

## Requirements
- R1: While `rstN` is low, and after reset until the first start pulse, `bitOut`, `bitValid`, `modQpsk` and `txReady` are all 0, and a start pulse given during reset has no effect.
- R2: Every frame opens with `PRE_LEN` one bits, followed by the delimiter 16'hF3A0 sent least significant bit first.
- R3: The header mode selects the fields that follow the delimiter. Mode 0 sends nothing more. Mode 1 sends the checksum. Mode 2 sends the 16-bit length and then the checksum. Mode 3 sends the 8-bit signal, the 8-bit service, the 16-bit length and then the checksum. Each data field is sent least significant bit first.
- R4: The checksum uses the polynomial x^16+x^12+x^5+1 (0x1021), preset to all ones, and shifts its register left one bit per covered bit. It covers only the data fields that lie between the delimiter and the checksum, so in mode 1 it covers nothing and sends 16'h0000. It is sent inverted, most significant bit first.
- R5: `modQpsk` is 0 on every clock on which `bitValid` is 1.
- R6: After the header, `modQpsk` equals the payload modulation request captured at start in modes 1 to 3, and is forced to 0 in mode 0.
- R7: With the constant-rate option captured as 1, each header bit is held on `bitOut` for two consecutive clocks; with 0, for one clock.
- R8: Let the header last D clocks, with clock 0 being the first clock after the accepted start edge. Then `txReady` is 1 from clock D-N onward, where N is the captured lead count (0 to 31). With N=0 it first rises on clock D, the first clock after the last header bit. It stays 1 until the next frame is accepted.
- R9: A start pulse is accepted only while the block is idle or in the payload phase. A start pulse during the header changes neither the bit stream nor the timing, even when the configuration inputs change at the same time. Inputs are read only on the accepting edge.
- R10: `bitValid` is 1 on exactly the D header clocks of a frame. `bitOut` is 0 whenever `bitValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Start pulse for a frame |
| hdrMode | input | 2 | Header mode, 0 to 3 |
| readyLead | input | LEAD_W | Clocks of ready lead before the payload |
| constRate | input | 1 | Hold each header bit for two clocks |
| payloadQpsk | input | 1 | Payload modulation request (1 = DQPSK) |
| signalIn | input | 8 | Signal field value |
| serviceIn | input | 8 | Service field value |
| lengthIn | input | 16 | Length field value |
| bitOut | output | 1 | Serial header bit |
| bitValid | output | 1 | A header bit is on `bitOut` |
| modQpsk | output | 1 | Modulation of the current bit (1 = DQPSK) |
| txReady | output | 1 | Data source may prepare the payload |

## Verification
The assertions assume that the start pulse lasts one clock, or that a held start is intended to restart the frame from the payload phase. They also assume that reset is asserted before the first clock. The stimulus raises the start pulse for exactly one clock per frame. It raises it again in the middle of a header only to probe that the pulse is ignored. It then sweeps all four modes, both rate options, several lead counts and both payload modulations. Each frame is compared clock by clock against a header stream and ready schedule built arithmetically in the bench.

// File: rtl/txhdr_pkg.sv
package txhdr_pkg;

  typedef enum logic [2:0] {
    FLD_IDLE,
    FLD_PRE,
    FLD_SFD,
    FLD_SIG,
    FLD_SVC,
    FLD_LEN,
    FLD_CRC,
    FLD_PAY
  } field_e;

  typedef struct packed {
    logic   start;    // frame accepted, capture configuration
    logic   step;     // advance to next header bit
    logic   load;     // current field finished, load next
    field_e loadFld;  // field to load
    logic   crcEn;    // current bit is covered by the checksum
  } hdr_strobe_t;

  localparam logic [15:0] SFD_WORD = 16'hF3A0;
  localparam logic [15:0] CRC_POLY = 16'h1021;

endpackage

// File: rtl/txhdr_ctrl.sv
module txhdr_ctrl
  import txhdr_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int LEAD_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [1:0]        modeIn,
  input  logic [LEAD_W-1:0] leadIn,
  input  logic              constIn,
  input  logic              qpskIn,
  output hdr_strobe_t       stb,
  output field_e            fieldQ,
  output logic              bitValid,
  output logic              modQpsk,
  output logic              txReady
);

  localparam int MAXF   = (PRE_LEN > 16) ? PRE_LEN : 16;
  localparam int CW     = $clog2(MAXF);
  localparam int MAXCLK = 2 * (PRE_LEN + 64);
  localparam int RW     = $clog2(MAXCLK + 1);

  logic [CW-1:0]     bitCnt;
  logic              half;
  logic [1:0]        modeL;
  logic [LEAD_W-1:0] leadL;
  logic              constL;
  logic              qpskL;
  logic [RW-1:0]     remain;

  logic   inHdr, accept, step, lastBit;
  field_e nxt;

  function automatic int fldLen(field_e f);
    case (f)
      FLD_PRE:          return PRE_LEN;
      FLD_SIG, FLD_SVC: return 8;
      default:          return 16;
    endcase
  endfunction

  function automatic field_e nextFld(field_e f, logic [1:0] m);
    case (f)
      FLD_PRE: return FLD_SFD;
      FLD_SFD: begin
        case (m)
          2'd0:    return FLD_PAY;
          2'd1:    return FLD_CRC;
          2'd2:    return FLD_LEN;
          default: return FLD_SIG;
        endcase
      end
      FLD_SIG: return FLD_SVC;
      FLD_SVC: return FLD_LEN;
      FLD_LEN: return FLD_CRC;
      default: return FLD_PAY;
    endcase
  endfunction

  function automatic logic [RW-1:0] hdrClocks(logic [1:0] m, logic cr);
    int bits;
    bits = PRE_LEN + 16 + 16 * int'(m);
    return RW'(cr ? 2 * bits : bits);
  endfunction

  always_comb begin
    inHdr   = (fieldQ != FLD_IDLE) && (fieldQ != FLD_PAY);
    accept  = startIn && !inHdr;
    step    = inHdr && (!constL || half);
    lastBit = step && (int'(bitCnt) == fldLen(fieldQ) - 1);
    nxt     = nextFld(fieldQ, modeL);
  end

  always_comb begin
    stb.start   = accept;
    stb.step    = step;
    stb.load    = lastBit;
    stb.loadFld = nxt;
    stb.crcEn   = step && (fieldQ inside {FLD_SIG, FLD_SVC, FLD_LEN});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldQ <= FLD_IDLE;
      bitCnt <= '0;
      half   <= 1'b0;
      modeL  <= '0;
      leadL  <= '0;
      constL <= 1'b0;
      qpskL  <= 1'b0;
      remain <= '0;
    end else if (accept) begin
      fieldQ <= FLD_PRE;
      bitCnt <= '0;
      half   <= 1'b0;
      modeL  <= modeIn;
      leadL  <= leadIn;
      constL <= constIn;
      qpskL  <= qpskIn;
      remain <= hdrClocks(modeIn, constIn);
    end else if (inHdr) begin
      half   <= constL ? ~half : 1'b0;
      remain <= remain - 1'b1;
      if (lastBit) begin
        fieldQ <= nxt;
        bitCnt <= '0;
      end else if (step) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign bitValid = inHdr;
  assign modQpsk  = (fieldQ == FLD_PAY) && qpskL && (modeL != 2'd0);
  assign txReady  = (fieldQ == FLD_PAY) || (inHdr && (remain <= RW'(leadL)));

  // R5: header bits are never flagged as DQPSK
  a_r5_hdr_bpsk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> !modQpsk);

  // R7: in constant-rate mode the first clock of a bit is followed by a repeat
  a_r7_bit_pair: assert property (@(posedge clk) disable iff (!rstN)
    (inHdr && constL && !half) |=> ($stable(fieldQ) && $stable(bitCnt)));

  // R8: once raised during the header, ready stays up into the payload
  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && fieldQ != FLD_PAY) |=> txReady);

  // R9: a start pulse during the header leaves the captured setup untouched
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && inHdr) |=> ($stable(modeL) && $stable(leadL) && $stable(constL)));

endmodule

// File: rtl/txhdr_dpath.sv
module txhdr_dpath
  import txhdr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hdr_strobe_t stb,
  input  field_e      fieldQ,
  input  logic [7:0]  sigIn,
  input  logic [7:0]  svcIn,
  input  logic [15:0] lenIn,
  output logic        bitOut
);

  logic [7:0]  sigL, svcL;
  logic [15:0] lenL, shReg, crcQ, crcNext;

  function automatic logic [15:0] crcStep(logic [15:0] c, logic b);
    logic [15:0] n;
    n = {c[14:0], 1'b0};
    if (c[15] ^ b) n = n ^ CRC_POLY;
    return n;
  endfunction

  function automatic logic [15:0] rev16(logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  assign crcNext = crcStep(crcQ, shReg[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigL  <= '0;
      svcL  <= '0;
      lenL  <= '0;
      shReg <= '0;
      crcQ  <= '1;
    end else if (stb.start) begin
      sigL <= sigIn;
      svcL <= svcIn;
      lenL <= lenIn;
      crcQ <= '1;
    end else begin
      if (stb.crcEn) crcQ <= crcNext;
      if (stb.load) begin
        case (stb.loadFld)
          FLD_SFD: shReg <= SFD_WORD;
          FLD_SIG: shReg <= {8'h00, sigL};
          FLD_SVC: shReg <= {8'h00, svcL};
          FLD_LEN: shReg <= lenL;
          FLD_CRC: shReg <= ~rev16(stb.crcEn ? crcNext : crcQ);
          default: shReg <= shReg;
        endcase
      end else if (stb.step) begin
        shReg <= {1'b0, shReg[15:1]};
      end
    end
  end

  always_comb begin
    case (fieldQ)
      FLD_IDLE, FLD_PAY: bitOut = 1'b0;
      FLD_PRE:           bitOut = 1'b1;
      default:           bitOut = shReg[0];
    endcase
  end

  // R2: the delimiter word is present when its field opens
  a_r2_sfd_load: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.loadFld == FLD_SFD && !stb.start) |=> (shReg == SFD_WORD));

  // R4: the checksum register moves only on covered bits or at frame start
  a_r4_crc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.crcEn && !stb.start) |=> $stable(crcQ));

endmodule

// File: rtl/txhdr_seq.sv
module txhdr_seq
  import txhdr_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int LEAD_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [1:0]        hdrMode,
  input  logic [LEAD_W-1:0] readyLead,
  input  logic              constRate,
  input  logic              payloadQpsk,
  input  logic [7:0]        signalIn,
  input  logic [7:0]        serviceIn,
  input  logic [15:0]       lengthIn,
  output logic              bitOut,
  output logic              bitValid,
  output logic              modQpsk,
  output logic              txReady
);

  hdr_strobe_t stb;
  field_e      fieldQ;

  txhdr_ctrl #(.PRE_LEN(PRE_LEN), .LEAD_W(LEAD_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .modeIn   (hdrMode),
    .leadIn   (readyLead),
    .constIn  (constRate),
    .qpskIn   (payloadQpsk),
    .stb      (stb),
    .fieldQ   (fieldQ),
    .bitValid (bitValid),
    .modQpsk  (modQpsk),
    .txReady  (txReady)
  );

  txhdr_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .fieldQ (fieldQ),
    .sigIn  (signalIn),
    .svcIn  (serviceIn),
    .lenIn  (lengthIn),
    .bitOut (bitOut)
  );

  // R10: no serial data outside the header
  a_r10_quiet_out: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> !bitOut);

endmodule

// File: tb/tb_txhdr_seq.sv
module tb_txhdr_seq;

  localparam int PRE = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [1:0] hdrMode = '0;
  logic [4:0] readyLead = '0;
  logic constRate = 1'b0;
  logic payloadQpsk = 1'b0;
  logic [7:0] signalIn = '0;
  logic [7:0] serviceIn = '0;
  logic [15:0] lengthIn = '0;
  logic bitOut, bitValid, modQpsk, txReady;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit expB [0:255];
  int nb;

  txhdr_seq #(.PRE_LEN(PRE), .LEAD_W(5)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .hdrMode(hdrMode),
    .readyLead(readyLead), .constRate(constRate), .payloadQpsk(payloadQpsk),
    .signalIn(signalIn), .serviceIn(serviceIn), .lengthIn(lengthIn),
    .bitOut(bitOut), .bitValid(bitValid), .modQpsk(modQpsk), .txReady(txReady)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog all-requirements actual=%0d cycles expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic addBits(logic [15:0] v, int w);
    for (int i = 0; i < w; i++) begin
      expB[nb] = v[i];
      nb++;
    end
  endtask

  // checksum per R4: register shifts left, feedback = msb xor data bit
  function automatic logic [15:0] crcAdd(logic [15:0] c, logic [15:0] v, int w);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < w; i++) begin
      if (r[15] ^ v[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic buildExp(int mode, logic [7:0] sg, logic [7:0] sv, logic [15:0] ln);
    logic [15:0] c;
    nb = 0;
    c = 16'hFFFF;
    for (int i = 0; i < PRE; i++) begin
      expB[nb] = 1'b1;
      nb++;
    end
    addBits(16'hF3A0, 16);
    if (mode == 3) begin
      addBits({8'h00, sg}, 8); c = crcAdd(c, {8'h00, sg}, 8);
      addBits({8'h00, sv}, 8); c = crcAdd(c, {8'h00, sv}, 8);
    end
    if (mode >= 2) begin
      addBits(ln, 16); c = crcAdd(c, ln, 16);
    end
    if (mode >= 1) begin
      c = ~c;
      for (int i = 15; i >= 0; i--) begin
        expB[nb] = c[i];
        nb++;
      end
    end
  endtask

  task automatic runFrame(int mode, int n, int cr, int q,
                          logic [7:0] sg, logic [7:0] sv, logic [15:0] ln, bit mid);
    int d, rep, eBit, eVal, eRdy, eHm, eMod, eRdy0;
    int badBit, badVal, badRdy, badHm, badMod;
    int aBit, xBit, aVal, xVal, aRdy, xRdy, aHm, aMod, xMod, badAt;
    buildExp(mode, sg, sv, ln);
    rep = cr ? 2 : 1;
    d = nb * rep;
    badBit = 0; badVal = 0; badRdy = 0; badHm = 0; badMod = 0;
    aBit = 0; xBit = 0; aVal = 0; xVal = 0; aRdy = 0; xRdy = 0; aHm = 0; aMod = 0; xMod = 0;
    badAt = 0;
    @(negedge clk);
    hdrMode = 2'(mode); readyLead = 5'(n); constRate = cr[0]; payloadQpsk = q[0];
    signalIn = sg; serviceIn = sv; lengthIn = ln;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    for (int k = 0; k < d + 4; k++) begin
      eRdy0 = d - n;
      if (k < d) begin
        eBit = expB[k / rep]; eVal = 1; eRdy = (k >= eRdy0) ? 1 : 0; eMod = 0;
        if (modQpsk !== 1'b0 && badHm == 0) begin badHm = 1; aHm = 1; end
      end else begin
        eBit = 0; eVal = 0; eRdy = 1; eMod = (q != 0 && mode != 0) ? 1 : 0;
        if (int'(modQpsk) != eMod && badMod == 0) begin badMod = 1; aMod = int'(modQpsk); xMod = eMod; end
      end
      if (int'(bitOut) != eBit && badBit == 0) begin
        badBit = 1; aBit = int'(bitOut); xBit = eBit; badAt = k;
      end
      if (int'(bitValid) != eVal && badVal == 0) begin badVal = 1; aVal = int'(bitValid); xVal = eVal; end
      if (int'(txReady) != eRdy && badRdy == 0) begin badRdy = 1; aRdy = int'(txReady); xRdy = eRdy; end
      if (mid && k == 3) begin
        startIn = 1'b1; hdrMode = ~hdrMode; readyLead = ~readyLead; constRate = ~constRate;
        payloadQpsk = ~payloadQpsk; signalIn = ~signalIn; serviceIn = ~serviceIn; lengthIn = ~lengthIn;
      end
      if (mid && k == 4) startIn = 1'b0;
      @(negedge clk);
    end
    if (badBit != 0) $display("  mode=%0d cr=%0d n=%0d first bit mismatch at clock %0d", mode, cr, n, badAt);
    chk(badBit == 0, cr ? "R2 R3 R4 R7 header stream" : "R2 R3 R4 header stream", aBit, xBit);
    chk(badVal == 0, "R10 valid window", aVal, xVal);
    chk(badRdy == 0, "R8 ready timing", aRdy, xRdy);
    chk(badHm == 0, "R5 header flagged bpsk", aHm, 0);
    chk(badMod == 0, "R6 payload modulation", aMod, xMod);
    if (mid) chk((badBit | badVal | badRdy | badHm | badMod) == 0, "R9 mid-header start ignored",
                 badBit + badVal + badRdy + badHm + badMod, 0);
  endtask

  initial begin
    // R1: reset state, start during reset has no effect
    startIn = 1'b1;
    repeat (3) @(negedge clk);
    chk({bitOut, bitValid, modQpsk, txReady} == 4'b0, "R1 outputs in reset",
        int'({bitOut, bitValid, modQpsk, txReady}), 0);
    startIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk({bitOut, bitValid, modQpsk, txReady} == 4'b0, "R1 idle after reset",
        int'({bitOut, bitValid, modQpsk, txReady}), 0);

    for (int mode = 0; mode < 4; mode++) begin
      for (int cr = 0; cr < 2; cr++) begin
        for (int ni = 0; ni < 4; ni++) begin
          int n;
          n = (ni == 0) ? 0 : (ni == 1) ? 1 : (ni == 2) ? 7 : 31;
          runFrame(mode, n, cr, (ni ^ mode) & 1,
                   8'(8'h5A + mode * 17 + ni), 8'(8'hC3 ^ (cr * 8'h21 + ni)),
                   16'(16'h1234 * (ni + 1) + mode * 16'h0F0F + cr), ni == 2);
        end
      end
    end

    // R3 R4: corner field values
    runFrame(3, 3, 0, 1, 8'h00, 8'h00, 16'h0000, 1'b0);
    runFrame(3, 3, 1, 0, 8'hFF, 8'hFF, 16'hFFFF, 1'b0);
    runFrame(1, 0, 0, 1, 8'hAA, 8'h55, 16'hBEEF, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule